// File: doc/BRIEF.md
# Power Mode Sequencer with Wake Qualification

This block steps a mixed-signal interface chip through its operating modes. After reset it holds the chip in undervoltage lockout. A rising supply-good flag starts a fuse-read interval of fixed length, and the chip then enters normal operation. In normal mode the serial interface, its output driver, the analog mux and the current sources are enabled, and the active-low wake output is driven low. A decoded enter-low-power command, and nothing else, moves the chip into low-power mode. There the fast oscillator and fault capture are shut off.

Wake requests come in two groups. The first group is an enabled input change of state and expiry of the interrupt timer, and these wake the chip at once. The second group is falling edges on the wake pin (only when configured), the interrupt pin and chip select. These pass through a one-cycle qualification state that samples the logic-supply-good flag. If the logic supply is low, the chip goes silently back to low power. If it is good, the chip enters normal mode and raises a wake report. A chip-select wake also marks the first serial reply as invalid. Every wake source passes through a two-flop synchronizer, and each edge is acted on only once. A supply drop returns the chip to lockout from any mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset `mode` is 0 (lockout), `spi_en`, `miso_en` and `amux_en` are 0, `osc_fast_en` is 1 and `wake_n` is 1.
- R2: With `supply_ok` high in lockout, the next cycle shows `mode` 1 (fuse read). Fuse read lasts exactly FUSE_CYC cycles, and then `mode` becomes 2 (normal).
- R3: In normal mode `spi_en`, `miso_en`, `amux_en` and `osc_fast_en` are 1 and `wake_n` is 0.
- R4: `lpm_cmd` in normal mode gives `mode` 3 (low power) on the next cycle. In every other mode `lpm_cmd` is ignored. In low power `osc_fast_en`, `spi_en`, `miso_en` and `amux_en` are 0 and `wake_n` is 1.
- R5: `supply_ok` low gives `mode` 0 on the next cycle, from any mode.
- R6: In low power, a rising `wake_cos` with `cos_en`=1, or a rising `timer_exp`, gives `mode` 2 with `wake_evt`=1 three cycles after the input changes. A rising `wake_cos` with `cos_en`=0 is ignored.
- R7: A falling `wake_pin_n` wakes the chip only when `wake_pin_en`=1. Otherwise it is ignored.
- R8: A qualified falling edge on `wake_pin_n`, `int_n` or `cs_n` in low power gives `mode` 4 (qualify) three cycles after the edge. On the cycle after that, `vddq_ok`=0 gives `mode` 3 with `wake_evt`=0, and `vddq_ok`=1 gives `mode` 2 with `wake_evt`=1. `wake_evt` clears on entry to low power.
- R9: `reply_invalid` goes to 1 only for a wake by `cs_n`. It clears on a `spi_reply` strobe in normal mode.
- R10: `fault_in` sets `fault_flag` only in normal mode. `fault_flag` clears on entry to low power, and a fault in low power leaves it at 0 after wake.
- R11: Each falling edge is acted on once. A wake pin held low after a rejected wake does not wake the chip again, even after `vddq_ok` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| supply_ok | input | 1 | Main supply above undervoltage threshold |
| lpm_cmd | input | 1 | Decoded enter-low-power command strobe |
| wake_cos | input | 1 | Input change-of-state detected |
| cos_en | input | 1 | Enable for change-of-state wake |
| timer_exp | input | 1 | Interrupt timer expired |
| wake_pin_n | input | 1 | Wake pin, falling edge wakes |
| wake_pin_en | input | 1 | Enable for wake pin as a wake source |
| int_n | input | 1 | Interrupt pin, falling edge wakes |
| cs_n | input | 1 | Chip select, falling edge wakes |
| vddq_ok | input | 1 | Logic supply good |
| spi_reply | input | 1 | Strobe: a serial reply has been sent |
| fault_in | input | 1 | Fault detector pulse |
| mode | output | 3 | 0 lockout, 1 fuse read, 2 normal, 3 low power, 4 qualify |
| spi_en | output | 1 | Serial interface enable |
| miso_en | output | 1 | Serial output driver enable |
| osc_fast_en | output | 1 | Fast oscillator enable |
| amux_en | output | 1 | Analog mux and current source enable |
| wake_n | output | 1 | Active-low wake output |
| wake_evt | output | 1 | Wake event report |
| reply_invalid | output | 1 | First serial reply after chip-select wake is invalid |
| fault_flag | output | 1 | Latched fault |

## Verification
The bench sweeps every pin source against every combination of wake-pin enable and logic-supply level, and predicts the resulting mode, wake report and reply-invalid flag. A design that skipped qualification would wake on a dead logic supply. A design that ignored the enable would wake from the wake pin when it should not. The bench holds chip select low across a rejected wake and then raises the logic supply. An edge detector that works from levels would then wake the chip a second time. The bench also measures the fuse-read length to the cycle, sends the low-power command outside normal mode, and injects faults in low power, which catches off-by-one counters and capture that leaks across modes.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    PM_UVLO  = 3'd0,
    PM_FUSE  = 3'd1,
    PM_NORM  = 3'd2,
    PM_LPM   = 3'd3,
    PM_CHECK = 3'd4
  } pm_mode_t;

  function automatic logic pm_fast_osc(input pm_mode_t m);
    return (m == PM_UVLO) || (m == PM_FUSE) || (m == PM_NORM);
  endfunction

  function automatic logic pm_active(input pm_mode_t m);
    return m == PM_NORM;
  endfunction

  function automatic logic pm_pin_allowed(input int idx, input logic wake_en);
    return (idx != 0) || wake_en;
  endfunction
endpackage

// File: rtl/pms_edge_sync.sv
module pms_edge_sync #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = s3 & ~s2;

  // R11: one edge yields a single-cycle event
  p_edge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fall || rise) |=> !(fall || rise));
endmodule

// File: rtl/pms_fuse_timer.sv
module pms_fuse_timer #(
  parameter int CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R2: every fuse interval starts counting from zero
  p_fuse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt == '0);
endmodule

// File: rtl/pms_wake_qual.sv
module pms_wake_qual (
  input  logic [2:0] pin_fall,
  input  logic       wake_pin_en,
  input  logic       cos_rise,
  input  logic       cos_en,
  input  logic       tmr_rise,
  output logic       direct_wake,
  output logic       pin_wake,
  output logic       cs_wake
);
  import pms_pkg::*;

  logic [2:0] allowed;

  for (genvar i = 0; i < 3; i++) begin : g_pin
    assign allowed[i] = pin_fall[i] & pm_pin_allowed(i, wake_pin_en);
  end

  assign direct_wake = (cos_rise & cos_en) | tmr_rise;
  assign pin_wake    = |allowed;
  assign cs_wake     = allowed[2];
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int FUSE_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       lpm_cmd,
  input  logic       wake_cos,
  input  logic       cos_en,
  input  logic       timer_exp,
  input  logic       wake_pin_n,
  input  logic       wake_pin_en,
  input  logic       int_n,
  input  logic       cs_n,
  input  logic       vddq_ok,
  input  logic       spi_reply,
  input  logic       fault_in,
  output logic [2:0] mode,
  output logic       spi_en,
  output logic       miso_en,
  output logic       osc_fast_en,
  output logic       amux_en,
  output logic       wake_n,
  output logic       wake_evt,
  output logic       reply_invalid,
  output logic       fault_flag
);
  import pms_pkg::*;

  pm_mode_t   state_q, state_d;
  logic [2:0] pins, pin_fall, pin_rise;
  logic       cos_rise, cos_fall, tmr_rise, tmr_fall;
  logic       direct_wake, pin_wake, cs_wake, fuse_done;
  logic       cs_hit_q, evt_q, inv_q, fault_q;
  logic       enter_lpm, woke;

  assign pins = {cs_n, int_n, wake_pin_n};

  for (genvar i = 0; i < 3; i++) begin : g_pin_sync
    pms_edge_sync #(.IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pins[i]),
      .rise(pin_rise[i]), .fall(pin_fall[i]));
  end

  pms_edge_sync #(.IDLE(1'b0)) u_cos_sync (
    .clk(clk), .rst_n(rst_n), .din(wake_cos), .rise(cos_rise), .fall(cos_fall));

  pms_edge_sync #(.IDLE(1'b0)) u_tmr_sync (
    .clk(clk), .rst_n(rst_n), .din(timer_exp), .rise(tmr_rise), .fall(tmr_fall));

  pms_wake_qual u_qual (
    .pin_fall(pin_fall), .wake_pin_en(wake_pin_en), .cos_rise(cos_rise),
    .cos_en(cos_en), .tmr_rise(tmr_rise), .direct_wake(direct_wake),
    .pin_wake(pin_wake), .cs_wake(cs_wake));

  pms_fuse_timer #(.CYC(FUSE_CYC)) u_fuse (
    .clk(clk), .rst_n(rst_n), .run(state_q == PM_FUSE), .done(fuse_done));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_UVLO:  if (supply_ok) state_d = PM_FUSE;
      PM_FUSE:  if (fuse_done) state_d = PM_NORM;
      PM_NORM:  if (lpm_cmd) state_d = PM_LPM;
      PM_LPM:   if (direct_wake) state_d = PM_NORM;
                else if (pin_wake) state_d = PM_CHECK;
      PM_CHECK: state_d = vddq_ok ? PM_NORM : PM_LPM;
      default:  state_d = PM_UVLO;
    endcase
    if (!supply_ok) state_d = PM_UVLO;
  end

  assign enter_lpm = (state_q == PM_NORM) && (state_d == PM_LPM);
  assign woke      = (state_q == PM_LPM || state_q == PM_CHECK) && (state_d == PM_NORM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PM_UVLO;
      cs_hit_q <= 1'b0;
      evt_q    <= 1'b0;
      inv_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PM_LPM && pin_wake) cs_hit_q <= cs_wake;
      if (enter_lpm) evt_q <= 1'b0;
      else if (woke) evt_q <= 1'b1;
      if (enter_lpm) inv_q <= 1'b0;
      else if (woke && state_q == PM_CHECK && cs_hit_q) inv_q <= 1'b1;
      else if (state_q == PM_NORM && spi_reply) inv_q <= 1'b0;
      if (enter_lpm) fault_q <= 1'b0;
      else if (state_q == PM_NORM && fault_in) fault_q <= 1'b1;
    end
  end

  assign mode          = state_q;
  assign spi_en        = pm_active(state_q);
  assign miso_en       = pm_active(state_q);
  assign amux_en       = pm_active(state_q);
  assign osc_fast_en   = pm_fast_osc(state_q);
  assign wake_n        = ~pm_active(state_q);
  assign wake_evt      = evt_q;
  assign reply_invalid = inv_q;
  assign fault_flag    = fault_q;

  // R5: supply loss forces lockout
  p_drop_uvlo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state_q == PM_UVLO);

  // R4: low power reached only through the command in normal mode
  p_lpm_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PM_LPM && state_q != PM_CHECK && !(state_q == PM_NORM && lpm_cmd))
      |=> state_q != PM_LPM);

  // R8: dead logic supply sends the chip back with no report
  p_vddq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_CHECK && !vddq_ok && supply_ok) |=> (state_q == PM_LPM && !evt_q));

  // R10: no fault held while in low power
  p_no_lpm_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PM_LPM |-> !fault_q);

  // R9: invalid-reply mark only after a chip-select wake
  p_inv_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_q) |-> $past(cs_hit_q));
endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
  localparam int FC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 0, lpm_cmd = 0, wake_cos = 0, cos_en = 0, timer_exp = 0;
  logic wake_pin_n = 1, wake_pin_en = 0, int_n = 1, cs_n = 1, vddq_ok = 1;
  logic spi_reply = 0, fault_in = 0;
  logic [2:0] mode;
  logic spi_en, miso_en, osc_fast_en, amux_en, wake_n, wake_evt, reply_invalid, fault_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.FUSE_CYC(FC)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lpm_cmd(lpm_cmd),
    .wake_cos(wake_cos), .cos_en(cos_en), .timer_exp(timer_exp),
    .wake_pin_n(wake_pin_n), .wake_pin_en(wake_pin_en), .int_n(int_n),
    .cs_n(cs_n), .vddq_ok(vddq_ok), .spi_reply(spi_reply), .fault_in(fault_in),
    .mode(mode), .spi_en(spi_en), .miso_en(miso_en), .osc_fast_en(osc_fast_en),
    .amux_en(amux_en), .wake_n(wake_n), .wake_evt(wake_evt),
    .reply_invalid(reply_invalid), .fault_flag(fault_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance n edges, sample 1 ns after the last
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // move to the next falling edge to drive inputs
  task automatic drv();
    @(negedge clk);
  endtask

  task automatic outs(input string req, input int on);
    chk({req, " spi_en"}, int'(spi_en), on);
    chk({req, " miso_en"}, int'(miso_en), on);
    chk({req, " amux_en"}, int'(amux_en), on);
    chk({req, " wake_n"}, int'(wake_n), 1 - on);
  endtask

  task automatic go_lpm();
    drv(); lpm_cmd = 1; tick(1);
    drv(); lpm_cmd = 0;
  endtask

  task automatic power_up();
    drv(); supply_ok = 1; tick(FC + 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int expm, expe, expi;
    tick(2);
    drv(); rst_n = 1; #1;
    // R1 reset state
    chk("R1 mode", int'(mode), 0);
    outs("R1", 0);
    chk("R1 osc_fast_en", int'(osc_fast_en), 1);

    // R4 command ignored in lockout
    drv(); lpm_cmd = 1; tick(1); drv(); lpm_cmd = 0; #1;
    chk("R4 lpm_cmd ignored in lockout", int'(mode), 0);

    // R2 fuse length
    drv(); supply_ok = 1; tick(1);
    chk("R2 fuse entered", int'(mode), 1);
    n = 0;
    while (mode == 3'd1 && n < 1000) begin n++; tick(1); end
    chk("R2 fuse cycles", n, FC);
    chk("R2 normal after fuse", int'(mode), 2);
    outs("R3", 1);
    chk("R3 osc_fast_en", int'(osc_fast_en), 1);

    // R5 drop during fuse read, with command ignored there (R4)
    drv(); supply_ok = 0; tick(1);
    chk("R5 drop from normal", int'(mode), 0);
    drv(); supply_ok = 1; tick(3);
    drv(); lpm_cmd = 1; tick(1); drv(); lpm_cmd = 0; #1;
    chk("R4 lpm_cmd ignored in fuse", int'(mode), 1);
    drv(); supply_ok = 0; tick(1);
    chk("R5 drop from fuse", int'(mode), 0);
    power_up();
    chk("R2 normal again", int'(mode), 2);

    // R10 fault capture in normal
    drv(); fault_in = 1; tick(1); drv(); fault_in = 0; #1;
    chk("R10 fault latched in normal", int'(fault_flag), 1);

    go_lpm(); #1;
    chk("R4 low power entered", int'(mode), 3);
    outs("R4", 0);
    chk("R4 osc_fast_en", int'(osc_fast_en), 0);
    chk("R10 fault cleared at entry", int'(fault_flag), 0);
    drv(); fault_in = 1; tick(1); drv(); fault_in = 0; tick(2);
    chk("R10 fault ignored in low power", int'(fault_flag), 0);

    // R6 change of state
    drv(); cos_en = 0; wake_cos = 1; tick(5);
    chk("R6 cos disabled ignored", int'(mode), 3);
    drv(); wake_cos = 0; tick(3);
    drv(); cos_en = 1; wake_cos = 1; tick(3);
    chk("R6 cos wake mode", int'(mode), 2);
    chk("R6 cos wake evt", int'(wake_evt), 1);
    chk("R10 no fault after wake", int'(fault_flag), 0);
    drv(); wake_cos = 0; cos_en = 0; tick(3);
    go_lpm(); #1;
    chk("R8 wake_evt cleared at entry", int'(wake_evt), 0);
    drv(); timer_exp = 1; tick(3);
    chk("R6 timer wake mode", int'(mode), 2);
    chk("R6 timer wake evt", int'(wake_evt), 1);
    drv(); timer_exp = 0; tick(3);
    go_lpm();

    // R7 R8 R9 sweep: source x enable x logic supply
    for (int src = 0; src < 3; src++) begin
      for (int en = 0; en < 2; en++) begin
        for (int vq = 0; vq < 2; vq++) begin
          drv(); wake_pin_en = en[0]; vddq_ok = vq[0];
          if (src == 0) wake_pin_n = 0; else if (src == 1) int_n = 0; else cs_n = 0;
          tick(3);
          if (src == 0 && en == 0) begin
            chk("R7 disabled wake pin stays", int'(mode), 3);
          end else begin
            chk("R8 qualify state", int'(mode), 4);
          end
          tick(1);
          expm = ((src != 0 || en == 1) && vq == 1) ? 2 : 3;
          expe = (expm == 2) ? 1 : 0;
          expi = (expm == 2 && src == 2) ? 1 : 0;
          chk("R8 sweep mode", int'(mode), expm);
          chk("R8 sweep wake_evt", int'(wake_evt), expe);
          chk("R9 sweep reply_invalid", int'(reply_invalid), expi);
          drv(); wake_pin_n = 1; int_n = 1; cs_n = 1; vddq_ok = 1; tick(3);
          if (mode == 3'd2) go_lpm();
        end
      end
    end

    // R11 held chip select, rejected then logic supply restored
    drv(); vddq_ok = 0; cs_n = 0; tick(4);
    chk("R11 rejected wake", int'(mode), 3);
    tick(6);
    drv(); vddq_ok = 1; tick(6);
    chk("R11 held level no second wake", int'(mode), 3);
    drv(); cs_n = 1; tick(3);
    drv(); cs_n = 0; tick(4);
    chk("R9 cs wake mode", int'(mode), 2);
    chk("R9 cs wake invalid", int'(reply_invalid), 1);
    drv(); spi_reply = 1; tick(1); drv(); spi_reply = 0; #1;
    chk("R9 reply clears invalid", int'(reply_invalid), 0);
    drv(); cs_n = 1; tick(3);

    // R5 drop from low power
    go_lpm();
    drv(); supply_ok = 0; tick(1);
    chk("R5 drop from low power", int'(mode), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule